// File: doc/BRIEF.md
# Sector Page-Write Load Controller

This block accepts host write strobes aimed at a flash segment that programs a whole 256-byte sector in one operation. Each qualified strobe delivers one byte, or in 16-bit mode one pair of bytes, into an on-block sector buffer. The first accepted write of a load opens a sector, and every later write lands in that sector. No command closes the load. Instead, a byte-load window timer closes it when no new strobe begins within the allowed interval after the previous one ended. The block then runs a fixed-length program phase, and all loaded bytes are committed together.

During the program phase the block raises `busy` and ignores host writes. Host reads return a status byte in place of buffer contents. Bytes of the sector that were not written during the load are flagged as not loaded, and their contents carry no meaning. Strobes are sampled in the clock domain. A write is the interval in which both active-low strobes are low. A pulse that is too short is discarded as noise. The write-protect input and the low-supply input each block the write they coincide with. All microsecond and millisecond intervals are counted in clock cycles.

Top module: `sector_load_ctrl`

## Requirements
- R1: After reset, `busy` and `prog_start` are 0, and `rd_loaded` is 0 for every offset.
- R2: In byte mode (`word_mode`=0), an accepted write stores `wdata[7:0]` at offset `addr[7:0]`, whether that offset is even or odd; once programming completes, a read of that offset returns the byte with `rd_loaded`=1.
- R3: In word mode (`word_mode`=1), `addr[7:1]` selects a word and `addr[0]` is ignored; `wdata[7:0]` goes to the even offset and `wdata[15:8]` to the odd offset, both in the same write.
- R4: Address, sector and mode are captured in the first cycle in which `ce_n` and `we_n` are both sampled low (the later of the two falls); data is captured in the first cycle in which either is sampled high; address or data changes within the pulse other than at those points have no effect.
- R5: A pulse whose combined-low width is fewer than `MIN_PULSE` cycles loads nothing and opens no load.
- R6: While loading, the window timer is paused while a strobe is held; if no strobe begins within `LOAD_WIN` cycles of the last accepted write, `busy` rises `LOAD_WIN`+1 clock edges after the edge that first samples the release of that write.
- R7: `busy` stays high for exactly `PROG_CYC` cycles; `prog_start` is high only in the first of them.
- R8: Writes issued while `busy` is high change no buffer byte or flag and do not open a new load.
- R9: A write completing while `wp`=1 or `low_supply`=1 is discarded; if it would have been the first write, no load opens.
- R10: `prog_sector` shows the sector (`addr[17:8]`) of the first accepted write of the load; later writes with another sector number still land in the open sector.
- R11: While `busy` is high, `rd_data` equals `STATUS_BYTE` (default 8'h80) and `rd_loaded` is 0.
- R12: The first accepted write of a new load clears all loaded flags, so offsets not written in that load read back with `rd_loaded`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Active-low card select strobe |
| we_n | input | 1 | Active-low write strobe |
| addr | input | 18 | [17:8] sector, [7:0] byte offset |
| wdata | input | 16 | Write data; [7:0] in byte mode, both bytes in word mode |
| word_mode | input | 1 | 1 = 16-bit write, 0 = byte write |
| wp | input | 1 | Write protect, active high |
| low_supply | input | 1 | Supply below threshold, active high |
| rd_offs | input | 8 | Read offset into the sector buffer |
| rd_data | output | 8 | Buffer byte, or status byte while busy |
| rd_loaded | output | 1 | Addressed byte was loaded in the last load |
| busy | output | 1 | Program phase in progress |
| prog_start | output | 1 | One-cycle pulse at the start of programming |
| prog_sector | output | 10 | Sector being loaded or programmed |

## Verification
The hardest case to create from the ports is a strobe whose two edges are split between the select and write pins while the address and data move inside the pulse. The stimulus lowers `ce_n` early with a decoy address. It then lowers `we_n` with the real address, changes address and data mid-pulse, and raises `we_n` before `ce_n`. The later read-back shows which values were latched. The timeout boundary is checked edge by edge, one cycle on each side of the expected `busy` rise. A write is also driven into the program phase, and the sector is then read back to show that nothing changed.

// File: rtl/sector_load_pkg.sv
package sector_load_pkg;

    localparam int SECT_W       = 10;
    localparam int OFFS_W       = 8;
    localparam int ADDR_W       = SECT_W + OFFS_W;
    localparam int BYTE_W       = 8;
    localparam int WORD_W       = 2 * BYTE_W;
    localparam int SECTOR_BYTES = 1 << OFFS_W;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOAD = 2'd1,
        PH_PROG = 2'd2
    } phase_e;

    typedef struct packed {
        logic [SECT_W-1:0] sector;
        logic [OFFS_W-1:0] offs;
        logic              word;
        logic [WORD_W-1:0] data;
    } wr_evt_t;

    // Does a write at offs (byte or word) cover buffer lane idx?
    function automatic logic lane_hit(input logic [OFFS_W-1:0] offs,
                                      input logic              word,
                                      input logic [OFFS_W-1:0] idx);
        if (word) return offs[OFFS_W-1:1] == idx[OFFS_W-1:1];
        return offs == idx;
    endfunction

    // Which data byte feeds a lane: upper byte only for odd lanes in word mode.
    function automatic logic [BYTE_W-1:0] lane_byte(input logic [WORD_W-1:0] data,
                                                    input logic              word,
                                                    input logic              odd);
        return (word && odd) ? data[WORD_W-1:BYTE_W] : data[BYTE_W-1:0];
    endfunction

endpackage

// File: rtl/strobe_qual.sv
module strobe_qual
    import sector_load_pkg::*;
#(
    parameter int MIN_PULSE = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              word_mode,
    output logic              strobe_act,
    output wr_evt_t           evt,
    output logic              evt_valid
);
    localparam int CNT_W = $clog2(MIN_PULSE + 1);

    logic              act, act_q;
    logic [CNT_W-1:0]  width_q;
    logic [SECT_W-1:0] sector_q;
    logic [OFFS_W-1:0] offs_q;
    logic              word_q;

    assign act        = !ce_n && !we_n;
    assign strobe_act = act;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q     <= 1'b0;
            width_q   <= '0;
            sector_q  <= '0;
            offs_q    <= '0;
            word_q    <= 1'b0;
            evt       <= '0;
            evt_valid <= 1'b0;
        end else begin
            act_q     <= act;
            evt_valid <= 1'b0;
            if (act && !act_q) begin
                // later of the two falling strobes: latch address and mode
                width_q  <= CNT_W'(1);
                sector_q <= addr[ADDR_W-1:OFFS_W];
                offs_q   <= addr[OFFS_W-1:0];
                word_q   <= word_mode;
            end else if (act && width_q < CNT_W'(MIN_PULSE)) begin
                width_q <= width_q + CNT_W'(1);
            end
            if (!act && act_q) begin
                // first rising strobe: latch data, qualify by width
                evt_valid <= (width_q >= CNT_W'(MIN_PULSE));
                evt       <= {sector_q, offs_q, word_q, wdata};
            end
        end
    end

endmodule

// File: rtl/load_timer.sv
module load_timer #(
    parameter int LOAD_WIN = 30000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic run,
    input  logic hold,
    output logic expire
);
    localparam int CNT_W = $clog2(LOAD_WIN + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                                  cnt_q <= '0;
        else if (start)                           cnt_q <= CNT_W'(LOAD_WIN);
        else if (run && !hold && cnt_q != '0)     cnt_q <= cnt_q - CNT_W'(1);
    end

    assign expire = run && !hold && !start && (cnt_q == CNT_W'(1));

endmodule

// File: rtl/sector_buf.sv
module sector_buf
    import sector_load_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr,
    input  logic                    wr,
    input  logic [OFFS_W-1:0]       offs,
    input  logic                    word,
    input  logic [WORD_W-1:0]       data,
    input  logic [OFFS_W-1:0]       rd_offs,
    output logic [BYTE_W-1:0]       rd_byte,
    output logic                    rd_loaded,
    output logic [SECTOR_BYTES-1:0] loaded_vec
);
    logic [BYTE_W-1:0]       mem_q  [SECTOR_BYTES];
    logic [BYTE_W-1:0]       lane_d [SECTOR_BYTES];
    logic [SECTOR_BYTES-1:0] hit_v;
    logic [SECTOR_BYTES-1:0] valid_q;

    for (genvar i = 0; i < SECTOR_BYTES; i++) begin : g_lane
        localparam logic [OFFS_W-1:0] IDX = OFFS_W'(i);
        assign hit_v[i]  = wr && lane_hit(offs, word, IDX);
        assign lane_d[i] = lane_byte(data, word, IDX[0]);
    end

    // contents are not reset: bytes never loaded carry no meaning
    always_ff @(posedge clk) begin
        for (int i = 0; i < SECTOR_BYTES; i++) begin
            if (hit_v[i]) mem_q[i] <= lane_d[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)      valid_q <= '0;
        else if (clr) valid_q <= hit_v;
        else          valid_q <= valid_q | hit_v;
    end

    assign rd_byte    = mem_q[rd_offs];
    assign rd_loaded  = valid_q[rd_offs];
    assign loaded_vec = valid_q;

endmodule

// File: rtl/sector_load_ctrl.sv
module sector_load_ctrl
    import sector_load_pkg::*;
#(
    parameter int          MIN_PULSE   = 3,
    parameter int          LOAD_WIN    = 30000,
    parameter int          PROG_CYC    = 2000000,
    parameter logic [7:0]  STATUS_BYTE = 8'h80
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              word_mode,
    input  logic              wp,
    input  logic              low_supply,
    input  logic [OFFS_W-1:0] rd_offs,
    output logic [BYTE_W-1:0] rd_data,
    output logic              rd_loaded,
    output logic              busy,
    output logic              prog_start,
    output logic [SECT_W-1:0] prog_sector
);
    localparam int PCNT_W = $clog2(PROG_CYC + 1);

    phase_e                  phase_q;
    logic [SECT_W-1:0]       sector_q;
    logic [PCNT_W-1:0]       prog_cnt_q;
    logic                    strobe_act, evt_valid, accept, open_new, expire;
    wr_evt_t                 evt;
    logic [BYTE_W-1:0]       buf_byte;
    logic                    buf_loaded;
    logic [SECTOR_BYTES-1:0] loaded_vec;

    strobe_qual #(.MIN_PULSE(MIN_PULSE)) u_qual (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .addr(addr),
        .wdata(wdata), .word_mode(word_mode), .strobe_act(strobe_act),
        .evt(evt), .evt_valid(evt_valid)
    );

    assign accept   = evt_valid && (phase_q != PH_PROG) && !wp && !low_supply;
    assign open_new = accept && (phase_q == PH_IDLE);

    load_timer #(.LOAD_WIN(LOAD_WIN)) u_timer (
        .clk(clk), .rst(rst), .start(accept), .run(phase_q == PH_LOAD),
        .hold(strobe_act), .expire(expire)
    );

    sector_buf u_buf (
        .clk(clk), .rst(rst), .clr(open_new), .wr(accept),
        .offs(evt.offs), .word(evt.word), .data(evt.data),
        .rd_offs(rd_offs), .rd_byte(buf_byte), .rd_loaded(buf_loaded),
        .loaded_vec(loaded_vec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= PH_IDLE;
            sector_q   <= '0;
            prog_cnt_q <= '0;
            prog_start <= 1'b0;
        end else begin
            prog_start <= 1'b0;
            unique case (phase_q)
                PH_IDLE: if (accept) begin
                    phase_q  <= PH_LOAD;
                    sector_q <= evt.sector;
                end
                PH_LOAD: if (expire) begin
                    phase_q    <= PH_PROG;
                    prog_cnt_q <= PCNT_W'(PROG_CYC);
                    prog_start <= 1'b1;
                end
                PH_PROG: begin
                    if (prog_cnt_q <= PCNT_W'(1)) phase_q <= PH_IDLE;
                    else                          prog_cnt_q <= prog_cnt_q - PCNT_W'(1);
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign busy        = (phase_q == PH_PROG);
    assign rd_data     = busy ? STATUS_BYTE : buf_byte;
    assign rd_loaded   = !busy && buf_loaded;
    assign prog_sector = sector_q;

endmodule

// File: rtl/sector_load_chk.sv
module sector_load_chk
    import sector_load_pkg::*;
#(
    parameter int MIN_PULSE = 3,
    parameter int PROG_CYC  = 2000000
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    ce_n,
    input logic                    we_n,
    input logic                    busy,
    input logic                    prog_start,
    input logic [SECT_W-1:0]       prog_sector,
    input logic                    evt_valid,
    input logic [SECTOR_BYTES-1:0] loaded_vec
);
    localparam int LW = $clog2(MIN_PULSE + 1);
    localparam int BW = $clog2(PROG_CYC + 2);

    logic [LW-1:0] low_run;
    logic [BW-1:0] busy_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_run  <= '0;
            busy_run <= '0;
        end else begin
            if (!ce_n && !we_n) begin
                if (low_run < LW'(MIN_PULSE)) low_run <= low_run + LW'(1);
            end else begin
                low_run <= '0;
            end
            if (busy) begin
                if (busy_run <= BW'(PROG_CYC)) busy_run <= busy_run + BW'(1);
            end else begin
                busy_run <= '0;
            end
        end
    end

    AST_SHORT_PULSE_DROPPED: assert property (@(posedge clk) disable iff (rst)
        evt_valid |-> ($past(low_run) >= LW'(MIN_PULSE)));                  // R5

    AST_PROG_START_FIRST: assert property (@(posedge clk) disable iff (rst)
        prog_start |-> (busy && !$past(busy)));                              // R7

    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (rst)
        busy |-> (busy_run < BW'(PROG_CYC)));                                // R7

    AST_BUSY_FLAGS_FROZEN: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(loaded_vec));                                       // R8

    AST_SECTOR_HELD: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(prog_sector));                                      // R10

endmodule

bind sector_load_ctrl sector_load_chk #(
    .MIN_PULSE(MIN_PULSE),
    .PROG_CYC (PROG_CYC)
) u_chk (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .busy(busy),
    .prog_start(prog_start), .prog_sector(prog_sector),
    .evt_valid(evt_valid), .loaded_vec(loaded_vec)
);

// File: tb/sector_load_ctrl_bench.sv
`timescale 1ns/1ps
module sector_load_ctrl_bench;
    import sector_load_pkg::*;

    localparam int         L  = 40;
    localparam int         P  = 60;
    localparam int         M  = 3;
    localparam logic [7:0] ST = 8'h80;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ce_n = 1'b1, we_n = 1'b1, word_mode = 1'b0;
    logic              wp = 1'b0, low_supply = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [WORD_W-1:0] wdata = '0;
    logic [OFFS_W-1:0] rd_offs = '0;
    logic [BYTE_W-1:0] rd_data;
    logic              rd_loaded, busy, prog_start;
    logic [SECT_W-1:0] prog_sector;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    sector_load_ctrl #(.MIN_PULSE(M), .LOAD_WIN(L), .PROG_CYC(P), .STATUS_BYTE(ST)) u_sector_load_ctrl (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .addr(addr), .wdata(wdata),
        .word_mode(word_mode), .wp(wp), .low_supply(low_supply), .rd_offs(rd_offs),
        .rd_data(rd_data), .rd_loaded(rd_loaded), .busy(busy), .prog_start(prog_start),
        .prog_sector(prog_sector)
    );

    function automatic logic [ADDR_W-1:0] mk(input int sec, input int offs);
        return {SECT_W'(sec), OFFS_W'(offs)};
    endfunction

    function automatic logic [7:0] lo_of(input int w);
        return 8'((w * 5 + 1) ^ 8'h3C);
    endfunction

    function automatic logic [7:0] hi_of(input int w);
        return 8'(w * 3 + 8'h40);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic strobe(input logic [ADDR_W-1:0] a, input logic [WORD_W-1:0] d,
                          input logic wm, input int width, input int gap);
        @(negedge clk);
        addr = a; wdata = d; word_mode = wm; ce_n = 1'b0; we_n = 1'b0;
        repeat (width) @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
        repeat (gap + 1) @(negedge clk);
    endtask

    task automatic rd(input int o, output logic [7:0] d, output logic l);
        @(negedge clk);
        rd_offs = OFFS_W'(o);
        #1;
        d = rd_data; l = rd_loaded;
    endtask

    task automatic wait_done(output int blen, output bit saw_start, output logic [SECT_W-1:0] sec);
        blen = 0; saw_start = 0; sec = '0;
        for (int i = 0; i < L + 40; i++) begin
            @(negedge clk);
            if (busy) break;
        end
        saw_start = prog_start;
        sec = prog_sector;
        for (int i = 0; i < P + 40; i++) begin
            if (!busy) break;
            blen++;
            @(negedge clk);
        end
    endtask

    task automatic stay_quiet(input int n, input string req);
        bit seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (busy) seen = 1;
        end
        chk(!seen, req, 32'(seen), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R7 watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0]        d;
        logic              l;
        int                blen;
        bit                ss;
        logic [SECT_W-1:0] sec;

        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk(!busy, "R1 busy", 32'(busy), 0);
        chk(!prog_start, "R1 prog_start", 32'(prog_start), 0);
        for (int i = 0; i < SECTOR_BYTES; i++) begin
            rd(i, d, l);
            chk(!l, "R1 loaded", 32'(l), 0);
        end

        // R2: byte-mode sweep over every offset of sector 3
        for (int i = 0; i < SECTOR_BYTES; i++)
            strobe(mk(3, i), 16'(8'(i * 37 + 11)) | 16'hAB00, 1'b0, M, 2);
        wait_done(blen, ss, sec);
        chk(blen == P, "R7 busy length", 32'(blen), 32'(P));
        chk(ss, "R7 prog_start", 32'(ss), 1);
        chk(sec == 10'd3, "R10 prog_sector", 32'(sec), 3);
        for (int i = 0; i < SECTOR_BYTES; i++) begin
            rd(i, d, l);
            chk(d == 8'(i * 37 + 11), "R2 data", 32'(d), 32'(8'(i * 37 + 11)));
            chk(l, "R2 loaded", 32'(l), 1);
        end

        // R6: exact timeout edge after a single write
        @(negedge clk);
        addr = mk(5, 9); wdata = 16'h005A; word_mode = 1'b0; ce_n = 1'b0; we_n = 1'b0;
        repeat (M) @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
        for (int n = 1; n <= L + 2; n++) begin
            @(negedge clk);
            if (n == L + 1) chk(!busy, "R6 early", 32'(busy), 0);
            if (n == L + 2) chk(busy, "R6 rise", 32'(busy), 1);
        end
        // R11: status read during programming
        rd_offs = 8'd9; #1;
        chk(rd_data == ST, "R11 status", 32'(rd_data), 32'(ST));
        chk(!rd_loaded, "R11 loaded", 32'(rd_loaded), 0);
        // R8: write during busy is ignored
        strobe(mk(5, 10), 16'h0011, 1'b0, M, 2);
        for (int i = 0; i < P + 20 && busy; i++) @(negedge clk);
        rd(9, d, l);
        chk(d == 8'h5A && l, "R6 data", 32'({l, d}), 32'h15A);
        rd(10, d, l);
        chk(!l, "R8 busy write", 32'(l), 0);
        rd(0, d, l);
        chk(!l, "R12 stale flag", 32'(l), 0);
        stay_quiet(L + 10, "R8 no new load");

        // R3: word-mode sweep over sector 7, addr[0] toggled
        for (int w = 0; w < SECTOR_BYTES / 2; w++)
            strobe(mk(7, w * 2 + (w & 1)), {hi_of(w), lo_of(w)}, 1'b1, M, 2);
        wait_done(blen, ss, sec);
        chk(sec == 10'd7, "R10 word sector", 32'(sec), 7);
        for (int i = 0; i < SECTOR_BYTES; i++) begin
            rd(i, d, l);
            chk(l && d == ((i & 1) ? hi_of(i / 2) : lo_of(i / 2)), "R3 word data",
                32'({l, d}), 32'({1'b1, ((i & 1) ? hi_of(i / 2) : lo_of(i / 2))}));
        end

        // R5: short pulses load nothing and open no load
        strobe(mk(4, 20), 16'h0066, 1'b0, 1, 2);
        strobe(mk(4, 20), 16'h0077, 1'b0, M - 1, 2);
        stay_quiet(L + 10, "R5 no load");
        strobe(mk(4, 21), 16'h0021, 1'b0, M, 2);
        wait_done(blen, ss, sec);
        rd(20, d, l);
        chk(!l, "R5 glitch loaded", 32'(l), 0);
        rd(21, d, l);
        chk(l && d == 8'h21, "R5 full pulse", 32'({l, d}), 32'h121);

        // R4: split strobe edges, mid-pulse changes; R10 sector lock
        @(negedge clk);
        addr = mk(2, 50); wdata = 16'h00FF; ce_n = 1'b0; we_n = 1'b1;
        @(negedge clk);
        addr = mk(2, 30); wdata = 16'h0001; we_n = 1'b0;
        @(negedge clk);
        addr = mk(2, 32); wdata = 16'h0002;
        @(negedge clk);
        wdata = 16'h003C;
        @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
        ce_n = 1'b1; wdata = 16'h00EE;
        repeat (2) @(negedge clk);
        strobe(mk(9, 31), 16'h0099, 1'b0, M, 2);
        wait_done(blen, ss, sec);
        chk(sec == 10'd2, "R10 locked sector", 32'(sec), 2);
        rd(30, d, l);
        chk(l && d == 8'h3C, "R4 capture", 32'({l, d}), 32'h13C);
        rd(50, d, l);
        chk(!l, "R4 early address", 32'(l), 0);
        rd(32, d, l);
        chk(!l, "R4 mid address", 32'(l), 0);
        rd(31, d, l);
        chk(l && d == 8'h99, "R10 foreign sector", 32'({l, d}), 32'h199);

        // R9: inhibited writes
        wp = 1'b1;
        strobe(mk(6, 40), 16'h0040, 1'b0, M, 2);
        wp = 1'b0;
        stay_quiet(L + 10, "R9 wp open");
        low_supply = 1'b1;
        strobe(mk(6, 40), 16'h0040, 1'b0, M, 2);
        low_supply = 1'b0;
        stay_quiet(L + 10, "R9 supply open");
        strobe(mk(6, 41), 16'h0041, 1'b0, M, 2);
        wp = 1'b1;
        strobe(mk(6, 42), 16'h0042, 1'b0, M, 2);
        wp = 1'b0;
        wait_done(blen, ss, sec);
        rd(41, d, l);
        chk(l && d == 8'h41, "R9 allowed", 32'({l, d}), 32'h141);
        rd(42, d, l);
        chk(!l, "R9 protected", 32'(l), 0);
        rd(40, d, l);
        chk(!l, "R12 cleared", 32'(l), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule